// File: doc/BRIEF.md
# Memory Waveform Playback Engine

This block plays a stored waveform out of external memory into a DAC. A fetch unit walks a sample buffer whose start address and length are programmed. It places reads on a simple request/grant memory port and keeps a small prefetch FIFO filled. A player stage takes samples out of that FIFO and scales each one by a calibrated gain and offset. It then presents the result to the DAC together with a strobe that marks each new code.

In one-buffer mode a new sample leaves on every core clock and the buffer wraps to its first sample with no gap. In streaming mode each sample is held for a programmable number of clocks. If the memory side cannot deliver in time, the output keeps the last code instead of dropping to zero, and a sticky underrun flag records the event. A configuration check refuses buffers that start off a 4096-byte page or that are shorter than 64 samples.

Top module: `wave_player`

## Requirements
- R1: When the buffer base address has any of its low 12 bits set, `cfg_err` is 1 and no memory request is issued while enabled.
- R2: When the buffer length is below 64 samples, `cfg_err` is 1 and no memory request is issued while enabled.
- R3: With `cfg_mode` = 0 (one-buffer), `dac_strobe` pulses on every clock once playback is flowing, the rate divider is ignored, and the sample after the last buffer entry is the first entry, with no gap.
- R4: With `cfg_mode` = 1 (streaming) and divider N, consecutive strobes are exactly N+1 clocks apart while data keeps up.
- R5: Each code equals the 16-bit template t (signed Q1.15) times the gain g (unsigned Q1.15), plus 16384, arithmetically shifted right by 15, plus the signed 16-bit offset. This sum is saturated to [-32768, 32767], and its top DAC_W bits form `dac_code` (two's complement).
- R6: When the FIFO runs dry after playback has started, `dac_code` keeps its last value, no strobe is given, `underrun` goes to 1, and playback resumes with the next buffer entry in order.
- R7: `underrun` stays 1 until a cycle with `underrun_clr` high, and a new underrun in the same cycle as the clear keeps it at 1.
- R8: After reset, `dac_code` is 0 and `dac_strobe`, `underrun` and `mem_req` are 0.
- R9: Request k (counted from 0 after enable, modulo length) targets byte address base + 2·k, which always lies within [base, base + 2·length).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Playback enable; low flushes the pipeline |
| cfg_mode | input | 1 | 0 one-buffer, 1 streaming |
| cfg_base | input | ADDR_W | Buffer start byte address |
| cfg_len | input | LEN_W | Buffer length in samples |
| cfg_rate_div | input | RATE_W | Streaming hold divider N (N+1 clocks per sample) |
| cfg_gain | input | 16 | Unsigned Q1.15 amplitude gain |
| cfg_offset | input | 16 | Signed offset added after scaling |
| cfg_err | output | 1 | Buffer configuration rejected |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | ADDR_W | Read byte address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read sample, signed Q1.15 |
| dac_code | output | DAC_W | Calibrated DAC code |
| dac_strobe | output | 1 | New code presented this cycle |
| underrun | output | 1 | Sticky starvation flag |
| underrun_clr | input | 1 | Clears the starvation flag |

## Verification
The bench attacks the buffer wrap in both modes. A design with an off-by-one wrap would repeat or skip an entry, or insert a one-clock hole between the last and first sample. Saturation is driven from both template extremes with gain near 2 and a large offset; a design without clamping would fold the code to the opposite sign. It then stalls the memory mid-run and checks that the output stays frozen and that playback resumes in order. A design that zeroes the output or loses its place in the buffer would fail there. It also clears the flag while starvation persists and checks that the flag stays set. Misaligned and short buffers must issue no reads at all.

// File: rtl/wave_player_pkg.sv
package wave_player_pkg;

    localparam int PAGE_BITS    = 12;
    localparam int MIN_SAMPLES  = 64;
    localparam int SAMPLE_W     = 16;
    localparam int FRAC_BITS    = 15;

    typedef enum logic {
        MODE_LOOP   = 1'b0,
        MODE_STREAM = 1'b1
    } play_mode_e;

    typedef logic signed [SAMPLE_W-1:0] q15_t;

    typedef struct packed {
        play_mode_e        mode;
        logic [15:0]       gain;
        logic signed [15:0] offset;
    } calib_cfg_t;

    // Scale a template sample, round half up, add offset, clamp to 16 bits.
    function automatic q15_t calibrate(input q15_t tmpl, input calib_cfg_t c);
        logic signed [33:0] prod;
        logic signed [33:0] acc;
        prod = tmpl * $signed({1'b0, c.gain});
        acc  = (prod + 34'sd16384) >>> FRAC_BITS;
        acc  = acc + $signed({{18{c.offset[15]}}, c.offset});
        if (acc > 34'sd32767)
            return 16'sh7FFF;
        else if (acc < -34'sd32768)
            return 16'sh8000;
        else
            return acc[15:0];
    endfunction

endpackage

// File: rtl/wp_fifo.sv
module wp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [PW:0]   wptr, rptr;
    logic          full;

    assign count = wptr - rptr;
    assign empty = (count == '0);
    assign full  = (count == (PW+1)'(DEPTH));
    assign dout  = store[rptr[PW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push && !full) begin
                store[wptr[PW-1:0]] <= din;
                wptr <= wptr + 1'b1;
            end
            if (pop && !empty)
                rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/wp_fetch.sv
module wp_fetch #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic [ADDR_W-1:0]          base,
    input  logic [LEN_W-1:0]           len,
    input  logic [$clog2(DEPTH):0]     fill,
    input  logic                       mem_gnt,
    input  logic                       mem_rvalid,
    output logic                       mem_req,
    output logic [ADDR_W-1:0]          mem_addr
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [LEN_W-1:0] idx;
    logic [CW-1:0]    inflight;
    logic [CW:0]      credits;
    logic             fire;

    assign credits  = {1'b0, fill} + {1'b0, inflight};
    assign mem_req  = run && (credits < (CW+1)'(DEPTH));
    assign mem_addr = base + ADDR_W'({idx, 1'b0});
    assign fire     = mem_req && mem_gnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            idx      <= '0;
            inflight <= '0;
        end else begin
            if (fire)
                idx <= (idx == len - 1'b1) ? '0 : idx + 1'b1;
            case ({fire, mem_rvalid})
                2'b10:   inflight <= inflight + 1'b1;
                2'b01:   inflight <= inflight - 1'b1;
                default: inflight <= inflight;
            endcase
        end
    end
endmodule

// File: rtl/wp_player.sv
module wp_player
    import wave_player_pkg::*;
#(
    parameter int DAC_W  = 14,
    parameter int RATE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [RATE_W-1:0]   rate_div,
    input  calib_cfg_t          cal,
    input  logic                fifo_empty,
    input  q15_t                fifo_dout,
    output logic                pop,
    output logic [DAC_W-1:0]    dac_code,
    output logic                dac_strobe,
    input  logic                underrun_clr,
    output logic                underrun
);
    logic [RATE_W-1:0] hold_cnt;
    logic              started;
    logic              starving;
    q15_t              scaled;

    assign scaled   = calibrate(fifo_dout, cal);
    assign pop      = run && (hold_cnt == '0) && !fifo_empty;
    assign starving = run && started && (hold_cnt == '0) && fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt   <= '0;
            started    <= 1'b0;
            dac_code   <= '0;
            dac_strobe <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            dac_strobe <= pop;
            if (!run) begin
                hold_cnt <= '0;
                started  <= 1'b0;
            end else if (pop) begin
                dac_code <= scaled[SAMPLE_W-1 -: DAC_W];
                hold_cnt <= (cal.mode == MODE_STREAM) ? rate_div : '0;
                started  <= 1'b1;
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
            if (starving)
                underrun <= 1'b1;
            else if (underrun_clr)
                underrun <= 1'b0;
        end
    end
endmodule

// File: rtl/wave_player.sv
module wave_player
    import wave_player_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24,
    parameter int RATE_W     = 16,
    parameter int DAC_W      = 14,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                cfg_mode,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [RATE_W-1:0]   cfg_rate_div,
    input  logic [15:0]         cfg_gain,
    input  logic [15:0]         cfg_offset,
    output logic                cfg_err,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [15:0]         mem_rdata,
    output logic [DAC_W-1:0]    dac_code,
    output logic                dac_strobe,
    output logic                underrun,
    input  logic                underrun_clr
);
    localparam int FILL_W = $clog2(FIFO_DEPTH) + 1;

    logic              en_q;
    logic              run;
    logic              pop;
    logic              fifo_empty;
    logic [FILL_W-1:0] fill;
    logic [15:0]       fifo_dout;
    calib_cfg_t        cal;

    assign cfg_err = (cfg_base[PAGE_BITS-1:0] != '0) ||
                     (cfg_len < LEN_W'(MIN_SAMPLES));
    assign run     = en_q && !cfg_err;
    assign cal     = '{mode: play_mode_e'(cfg_mode), gain: cfg_gain,
                       offset: cfg_offset};

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en;
    end

    wp_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(FIFO_DEPTH)) fetch_i (
        .clk(clk), .rst(rst), .run(run), .base(cfg_base), .len(cfg_len),
        .fill(fill), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_req(mem_req), .mem_addr(mem_addr)
    );

    wp_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .flush(!run), .push(mem_rvalid && run),
        .din(mem_rdata), .pop(pop), .dout(fifo_dout), .empty(fifo_empty),
        .count(fill)
    );

    wp_player #(.DAC_W(DAC_W), .RATE_W(RATE_W)) player_i (
        .clk(clk), .rst(rst), .run(run), .rate_div(cfg_rate_div), .cal(cal),
        .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .pop(pop),
        .dac_code(dac_code), .dac_strobe(dac_strobe),
        .underrun_clr(underrun_clr), .underrun(underrun)
    );
endmodule

// File: rtl/wave_player_chk.sv
module wave_player_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24,
    parameter int RATE_W = 16,
    parameter int DAC_W  = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_mode,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [LEN_W-1:0]  cfg_len,
    input logic [RATE_W-1:0] cfg_rate_div,
    input logic              cfg_err,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DAC_W-1:0]  dac_code,
    input logic              dac_strobe,
    input logic              underrun,
    input logic              underrun_clr
);
    AST_NO_REQ_BAD_CFG: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !mem_req); // R1
    AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (cfg_len >= LEN_W'(64))); // R2
    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr >= cfg_base &&
                     mem_addr < cfg_base + ADDR_W'({cfg_len, 1'b0}))); // R9
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !dac_strobe |-> $stable(dac_code)); // R6
    AST_RATE_GAP: assert property (@(posedge clk) disable iff (rst)
        (dac_strobe && cfg_mode && cfg_rate_div != '0) |=> !dac_strobe); // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(underrun) |-> $past(underrun_clr)); // R7
endmodule

bind wave_player wave_player_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RATE_W(RATE_W), .DAC_W(DAC_W)
) chk_i (.*);

// File: tb/wave_player_tb_top.sv
`timescale 1ns/1ps
module wave_player_tb_top;
    localparam int AW = 32, LW = 24, RW = 16, DW = 14;

    logic          clk = 1'b0, rst = 1'b1, en = 1'b0, cfg_mode = 1'b0;
    logic [AW-1:0] cfg_base = 32'h3000;
    logic [LW-1:0] cfg_len = 24'd64;
    logic [RW-1:0] cfg_rate_div = '0;
    logic [15:0]   cfg_gain = 16'h8000, cfg_offset = '0;
    logic          cfg_err, mem_req, mem_gnt, mem_rvalid = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata = '0;
    logic [DW-1:0] dac_code;
    logic          dac_strobe, underrun, underrun_clr = 1'b0;
    logic          gate = 1'b1;

    int n_checks = 0, n_fail = 0;

    always #2 clk = ~clk;

    wave_player dut_i (
        .clk(clk), .rst(rst), .en(en), .cfg_mode(cfg_mode), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_rate_div(cfg_rate_div), .cfg_gain(cfg_gain),
        .cfg_offset(cfg_offset), .cfg_err(cfg_err), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .dac_code(dac_code), .dac_strobe(dac_strobe),
        .underrun(underrun), .underrun_clr(underrun_clr)
    );

    function automatic int tmpl(int i);
        int v;
        if (i % 64 == 0) return 32767;
        if (i % 64 == 1) return -32768;
        v = (i * 1237 + 311) & 16'hFFFF;
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    function automatic int expect_code(int t, int g, int o);
        longint r;
        r = (longint'(t) * longint'(g) + 64'sd16384) >>> 15;
        r = r + o;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r) >>> (16 - DW);
    endfunction

    // Memory model: one-cycle read latency, grant follows the gate.
    assign mem_gnt = gate;
    always_ff @(posedge clk) begin
        mem_rvalid <= mem_req && mem_gnt;
        mem_rdata  <= 16'(tmpl(int'((mem_addr - cfg_base) >> 1)));
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int code_i();
        return int'($signed(dac_code));
    endfunction

    typedef struct packed {
        bit        mode;
        bit [7:0]  div;
        bit [15:0] gain;
        bit [15:0] off;
        bit [11:0] len;
        bit [31:0] base;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 8'd5, 16'h8000, 16'h0000, 12'd64, 32'h0000_3000},
        '{1'b0, 8'd0, 16'hFFFF, 16'h1000, 12'd70, 32'h0001_0000},
        '{1'b1, 8'd0, 16'h4000, 16'hFF38, 12'd64, 32'h0000_3000},
        '{1'b1, 8'd3, 16'h8000, 16'h7FFF, 12'd65, 32'h0002_0000},
        '{1'b1, 8'd1, 16'h0000, 16'hF000, 12'd64, 32'h0000_5000}
    };

    task automatic play_vector(vec_t v);
        int idx = 0, fidx = 0, n = 0, last = 0, cyc = 0, gap;
        string rq;
        cfg_mode = v.mode; cfg_rate_div = RW'(v.div); cfg_gain = v.gain;
        cfg_offset = v.off; cfg_len = LW'(v.len); cfg_base = v.base;
        gap = v.mode ? int'(v.div) + 1 : 1;
        rq  = v.mode ? "R4" : "R3";
        @(negedge clk); en = 1'b1;
        while (n < int'(v.len) + 8 && cyc < 5000) begin
            @(negedge clk); cyc++;
            if (mem_req && mem_gnt) begin
                check(mem_addr == v.base + 32'(2 * fidx), "R9", "read address",
                      int'(mem_addr), int'(v.base) + 2 * fidx);
                fidx = (fidx + 1) % int'(v.len);
            end
            if (dac_strobe) begin
                check(code_i() == expect_code(tmpl(idx), int'(v.gain),
                      int'($signed(v.off))), "R5", "scaled code", code_i(),
                      expect_code(tmpl(idx), int'(v.gain), int'($signed(v.off))));
                if (n > 0) check(cyc - last == gap, rq, "strobe spacing",
                                 cyc - last, gap);
                last = cyc; n++;
                idx = (idx + 1) % int'(v.len);
            end
        end
        check(n >= int'(v.len) + 8, rq, "strobes seen", n, int'(v.len) + 8);
        check(underrun == 1'b0, "R6", "no false underrun", int'(underrun), 0);
        en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bad_cfg(logic [31:0] b, int l, string rq);
        int reqs = 0;
        cfg_base = b; cfg_len = LW'(l); cfg_mode = 1'b0;
        @(negedge clk); en = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        check(cfg_err == 1'b1, rq, "cfg_err", int'(cfg_err), 1);
        check(reqs == 0, rq, "requests issued", reqs, 0);
        en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic starve_test();
        int idx = 0, quiet = 0, cyc = 0, held, strobes = 0, ok_stable = 1;
        cfg_mode = 1'b1; cfg_rate_div = '0; cfg_gain = 16'h8000;
        cfg_offset = '0; cfg_len = 24'd64; cfg_base = 32'h5000; gate = 1'b1;
        @(negedge clk); en = 1'b1;
        while (idx < 10 && cyc < 200) begin
            @(negedge clk); cyc++;
            if (dac_strobe) idx++;
        end
        gate = 1'b0;
        while (quiet < 3 && cyc < 400) begin
            @(negedge clk); cyc++;
            if (dac_strobe) begin quiet = 0; idx++; end
            else quiet++;
        end
        check(underrun == 1'b1, "R6", "underrun flag on starvation", int'(underrun), 1);
        check(code_i() == expect_code(tmpl(idx - 1), 32768, 0), "R6",
              "held last code", code_i(), expect_code(tmpl(idx - 1), 32768, 0));
        held = code_i();
        repeat (10) begin
            @(negedge clk);
            if (dac_strobe) strobes++;
            if (code_i() != held) ok_stable = 0;
        end
        check(strobes == 0, "R6", "strobes while starved", strobes, 0);
        check(ok_stable == 1, "R6", "code stable while starved", ok_stable, 1);
        underrun_clr = 1'b1;
        @(negedge clk); underrun_clr = 1'b0;
        check(underrun == 1'b1, "R7", "set wins over clear", int'(underrun), 1);
        gate = 1'b1;
        cyc = 0;
        while (!dac_strobe && cyc < 20) begin @(negedge clk); cyc++; end
        check(code_i() == expect_code(tmpl(idx), 32768, 0), "R6",
              "resume with next entry", code_i(), expect_code(tmpl(idx), 32768, 0));
        repeat (3) @(negedge clk);
        underrun_clr = 1'b1;
        @(negedge clk); underrun_clr = 1'b0;
        check(underrun == 1'b0, "R7", "flag cleared", int'(underrun), 0);
        repeat (5) @(negedge clk);
        check(underrun == 1'b0, "R7", "flag stays clear", int'(underrun), 0);
        en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dac_code == '0, "R8", "reset code", code_i(), 0);
        check(dac_strobe == 1'b0, "R8", "reset strobe", int'(dac_strobe), 0);
        check(underrun == 1'b0, "R8", "reset flag", int'(underrun), 0);
        check(mem_req == 1'b0, "R8", "reset request", int'(mem_req), 0);

        for (int k = 0; k < 5; k++) play_vector(VECS[k]);

        bad_cfg(32'h0000_3004, 64, "R1");
        bad_cfg(32'h0000_3800, 64, "R1");
        bad_cfg(32'h0000_4000, 63, "R2");

        starve_test();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule